// File: doc/BRIEF.md
# Sixteen-Line GPIO Controller with Per-Line Interrupt Triggers

The block gives software sixteen bidirectional pins behind a small word-wide register bus. Each pin can be driven from an output data register or left as an input, selected per line by a direction register in which a 1 means input. Every pin is brought through a two-flop synchronizer. The synchronized values can be read back, and they feed an interrupt detector.

Each line has a 3-bit trigger code that selects high level, low level, rising edge, falling edge or either edge. The codes for lines 0-7 sit in one style register and those for lines 8-15 in a second. A detected event sets a sticky status bit, which software clears by writing 1 to it. Lines 0 to 12 each have a dedicated active-high interrupt output that follows that line's status bit. Lines 13 to 15 raise status only.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset the output data, status and both style registers read 0, the direction register reads 0x0000FFFF (all inputs), pin_oe_o is 0 and irq_o is 0.
- R2: Offset 0x00 holds the 16-bit output data; pin_o presents it, and bits 31:16 read as 0.
- R3: Offset 0x04 is the direction register; a 1 in bit i makes line i an input (pin_oe_o[i]=0), and a 0 lets the line drive (pin_oe_o[i]=1).
- R4: Offset 0x08 returns the synchronized pins; a change on pin_i appears there after exactly two rising clock edges.
- R5: Offsets 0x10 and 0x14 are 24-bit style registers for lines 0-7 and 8-15. Line n uses bits [3k+2:3k] with k = n mod 8. Bits 31:24 read as 0.
- R6: Code 0 (high level) and code 1 (low level) set the status bit on every cycle in which the synchronized pin has that level, so a clear only takes effect once the level has gone away.
- R7: Code 2 (rising), code 3 (falling) and code 4 (either edge) set the status bit once, on the edge, one edge after the synchronized value changes; the bit then stays set until it is cleared.
- R8: Codes 5, 6 and 7 never set a status bit.
- R9: Offset 0x0C is the status register. Writing 1 clears a bit and writing 0 leaves it unchanged. An event and a clear of the same bit in the same cycle leave the bit set.
- R10: irq_o[i] equals status bit i for lines 0 to 12; lines 13 to 15 have no interrupt output.
- R11: Offsets 0x18 and 0x1C and all other unmapped offsets read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_en_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Write when 1, read when 0 |
| bus_addr_i | input | 5 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from bus_addr_i |
| pin_i | input | 16 | Pin input levels, asynchronous |
| pin_o | output | 16 | Pin output levels |
| pin_oe_o | output | 16 | Per-pin drive enable, 1 = drive |
| irq_o | output | 13 | Interrupt outputs for lines 0 to 12 |

## Verification
Two functions can act on the same status bit in the same cycle: a new trigger event and a write-1-to-clear from the bus. To provoke this, the bench sets a status bit with an either-edge line. It then toggles that pin and times a clear write so that the write edge is the same edge on which the toggle reaches the detector. The bit must read back as set afterwards. The case is judged against a second clear issued with no event pending, which must leave the bit at 0. The level-mode case is covered as well: a clear issued while the level holds must be undone on the next cycle.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [2:0] {
    STY_HIGH = 3'd0,
    STY_LOW  = 3'd1,
    STY_RISE = 3'd2,
    STY_FALL = 3'd3,
    STY_BOTH = 3'd4
  } gpio_style_e;

  localparam int unsigned STY_W = 3;

  localparam logic [7:0] OFF_DOUT = 8'h00;
  localparam logic [7:0] OFF_DIR  = 8'h04;
  localparam logic [7:0] OFF_DIN  = 8'h08;
  localparam logic [7:0] OFF_STAT = 8'h0C;
  localparam logic [7:0] OFF_STYA = 8'h10;
  localparam logic [7:0] OFF_STYB = 8'h14;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_trig.sv
module gpio_trig
  import gpio_irq_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [W-1:0]     sync_i,
  input  logic [STY_W*W-1:0] style_i,
  output logic [W-1:0]     hit_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sync_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_line
    logic [STY_W-1:0] code;
    logic             rise, fall;
    assign code = style_i[STY_W*i +: STY_W];
    assign rise = sync_i[i] & ~prev_q[i];
    assign fall = ~sync_i[i] & prev_q[i];

    always_comb begin
      case (code)
        STY_HIGH: hit_o[i] = sync_i[i];
        STY_LOW:  hit_o[i] = ~sync_i[i];
        STY_RISE: hit_o[i] = rise;
        STY_FALL: hit_o[i] = fall;
        STY_BOTH: hit_o[i] = rise | fall;
        default:  hit_o[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_stat.sv
module gpio_stat #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] hit_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] stat_q;

  // a new event outranks a clear of the same bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~clr_i) | hit_i;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 16,
  parameter int unsigned IRQ_LINES = 13,
  parameter int unsigned AW        = 5,
  parameter int unsigned DW        = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bus_en_i,
  input  logic                 bus_we_i,
  input  logic [AW-1:0]        bus_addr_i,
  input  logic [DW-1:0]        bus_wdata_i,
  output logic [DW-1:0]        bus_rdata_o,
  input  logic [NUM_LINES-1:0] pin_i,
  output logic [NUM_LINES-1:0] pin_o,
  output logic [NUM_LINES-1:0] pin_oe_o,
  output logic [IRQ_LINES-1:0] irq_o
);
  localparam int unsigned HALF = NUM_LINES / 2;
  localparam int unsigned SW   = STY_W * HALF;

  logic [NUM_LINES-1:0]       out_q, dir_q, sync, hit, stat_q, clr;
  logic [STY_W*NUM_LINES-1:0] sty_q;
  logic                       wr_en;
  logic                       unused_wdata;

  assign wr_en        = bus_en_i & bus_we_i;
  assign unused_wdata = ^bus_wdata_i[DW-1:SW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      dir_q <= '1;
      sty_q <= '0;
    end else if (wr_en) begin
      if (bus_addr_i == AW'(OFF_DOUT)) out_q <= bus_wdata_i[NUM_LINES-1:0];
      if (bus_addr_i == AW'(OFF_DIR))  dir_q <= bus_wdata_i[NUM_LINES-1:0];
      if (bus_addr_i == AW'(OFF_STYA)) sty_q[SW-1:0]    <= bus_wdata_i[SW-1:0];
      if (bus_addr_i == AW'(OFF_STYB)) sty_q[2*SW-1:SW] <= bus_wdata_i[SW-1:0];
    end
  end

  assign clr = (wr_en && bus_addr_i == AW'(OFF_STAT)) ? bus_wdata_i[NUM_LINES-1:0] : '0;

  gpio_sync #(.W(NUM_LINES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (sync)
  );

  gpio_trig #(.W(NUM_LINES)) u_trig (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_i (sync),
    .style_i(sty_q),
    .hit_o  (hit)
  );

  gpio_stat #(.W(NUM_LINES)) u_stat (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .hit_i (hit),
    .clr_i (clr),
    .stat_o(stat_q)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == AW'(OFF_DOUT))      bus_rdata_o = DW'(out_q);
    else if (bus_addr_i == AW'(OFF_DIR))  bus_rdata_o = DW'(dir_q);
    else if (bus_addr_i == AW'(OFF_DIN))  bus_rdata_o = DW'(sync);
    else if (bus_addr_i == AW'(OFF_STAT)) bus_rdata_o = DW'(stat_q);
    else if (bus_addr_i == AW'(OFF_STYA)) bus_rdata_o = DW'(sty_q[SW-1:0]);
    else if (bus_addr_i == AW'(OFF_STYB)) bus_rdata_o = DW'(sty_q[2*SW-1:SW]);
  end

  assign pin_o    = out_q;
  assign pin_oe_o = ~dir_q;
  assign irq_o    = stat_q[IRQ_LINES-1:0];
endmodule

// File: rtl/gpio_irq_unit_chk.sv
module gpio_irq_unit_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 16,
  parameter int unsigned IRQ_LINES = 13,
  parameter int unsigned AW        = 5,
  parameter int unsigned DW        = 32
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       bus_en_i,
  input logic                       bus_we_i,
  input logic [AW-1:0]              bus_addr_i,
  input logic [DW-1:0]              bus_wdata_i,
  input logic [DW-1:0]              bus_rdata_o,
  input logic [NUM_LINES-1:0]       pin_oe_o,
  input logic [IRQ_LINES-1:0]       irq_o,
  input logic [NUM_LINES-1:0]       stat_i,
  input logic [NUM_LINES-1:0]       hit_i,
  input logic [STY_W*NUM_LINES-1:0] sty_i
);
  logic [NUM_LINES-1:0] clr_mask, res_mask;

  assign clr_mask = (bus_en_i && bus_we_i && bus_addr_i == AW'(OFF_STAT))
                    ? bus_wdata_i[NUM_LINES-1:0] : '0;

  always_comb begin
    for (int i = 0; i < NUM_LINES; i++)
      res_mask[i] = (sty_i[STY_W*i +: STY_W] > 3'd4);
  end

  // R8
  a_r8_reserved_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i & res_mask) == '0);

  // R9: a bit only rises after a trigger event
  a_r9_set_needs_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_i & ~$past(stat_i) & ~$past(hit_i)) == '0);

  // R9: a bit only falls after a 1 written to it
  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(stat_i) & ~$past(clr_mask) & ~stat_i) == '0);

  // R10
  a_r10_irq_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == AW'(OFF_STAT)) |-> (bus_rdata_o[IRQ_LINES-1:0] == irq_o));

  // R3
  a_r3_dir_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == AW'(OFF_DIR)) |-> (bus_rdata_o[NUM_LINES-1:0] == ~pin_oe_o));

  // R11
  a_r11_hole_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == AW'(8'h18) || bus_addr_i == AW'(8'h1C)) |-> (bus_rdata_o == '0));
endmodule

bind gpio_irq_unit gpio_irq_unit_chk #(
  .NUM_LINES(NUM_LINES), .IRQ_LINES(IRQ_LINES), .AW(AW), .DW(DW)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_en_i   (bus_en_i),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .bus_wdata_i(bus_wdata_i),
  .bus_rdata_o(bus_rdata_o),
  .pin_oe_o   (pin_oe_o),
  .irq_o      (irq_o),
  .stat_i     (stat_q),
  .hit_i      (hit),
  .sty_i      (sty_q)
);

// File: tb/gpio_irq_unit_bench.sv
module gpio_irq_unit_bench;
  localparam int K_RD = 0, K_IRQ = 1, K_PO = 2, K_OE = 3;

  typedef struct {
    int          kind;
    logic [4:0]  addr;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] pin = '0, pin_out, pin_oe;
  logic [12:0] irq;

  item_t exp_q[$];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_irq_unit u_gpio_irq_unit (
    .clk_i(clk), .rst_ni(rst_n), .bus_en_i(en), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pin_i(pin), .pin_o(pin_out), .pin_oe_o(pin_oe), .irq_o(irq)
  );

  // monitor
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = exp_q.pop_front();
      case (it.kind)
        K_RD:    act = rdata;
        K_IRQ:   act = 32'(irq);
        K_PO:    act = 32'(pin_out);
        default: act = 32'(pin_oe);
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expect_at(int kind, logic [4:0] a, logic [31:0] e, string tag);
    @(posedge clk); #2;
    if (kind == K_RD) addr = a;
    exp_q.push_back('{kind: kind, addr: a, exp: e, tag: tag});
    @(negedge clk); #1;
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(posedge clk); #2;
    en = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #2;
    en = 1'b0; we = 1'b0;
  endtask

  task automatic set_pin(logic [15:0] v);
    @(posedge clk); #2;
    pin = v;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  initial begin
    idle(3);
    #5 rst_n = 1'b1;

    // R1 reset state
    expect_at(K_RD, 5'h00, 32'h0, "R1 dout");
    expect_at(K_RD, 5'h04, 32'h0000FFFF, "R1 dir");
    expect_at(K_RD, 5'h0C, 32'h0, "R1 stat");
    expect_at(K_RD, 5'h10, 32'h0, "R1 style a");
    expect_at(K_RD, 5'h14, 32'h0, "R1 style b");
    expect_at(K_OE, 5'h00, 32'h0, "R1 pin_oe");
    expect_at(K_IRQ, 5'h00, 32'h0, "R1 irq");

    // R2 output data
    wr(5'h00, 32'h1234ABCD);
    expect_at(K_RD, 5'h00, 32'h0000ABCD, "R2 dout read");
    expect_at(K_PO, 5'h00, 32'h0000ABCD, "R2 pin_o");

    // R3 direction
    wr(5'h04, 32'h000000FF);
    expect_at(K_OE, 5'h00, 32'h0000FF00, "R3 pin_oe");
    expect_at(K_RD, 5'h04, 32'h000000FF, "R3 dir read");

    // R4 sync latency; styles all high-level -> R6
    set_pin(16'h5A5A);
    expect_at(K_RD, 5'h08, 32'h0, "R4 after one edge");
    expect_at(K_RD, 5'h08, 32'h00005A5A, "R4 after two edges");
    expect_at(K_RD, 5'h0C, 32'h00005A5A, "R6 level high sets");
    expect_at(K_IRQ, 5'h00, 32'h00001A5A, "R10 irq lines 0-12 only");
    wr(5'h0C, 32'h0);
    expect_at(K_RD, 5'h0C, 32'h00005A5A, "R9 write 0 no effect");
    wr(5'h0C, 32'hFFFF);
    expect_at(K_RD, 5'h0C, 32'h00005A5A, "R6 clear undone while level held");
    set_pin(16'h0000);
    idle(3);
    wr(5'h0C, 32'h000F);
    expect_at(K_RD, 5'h0C, 32'h00005A50, "R9 partial clear");
    wr(5'h0C, 32'hFFFF);
    expect_at(K_RD, 5'h0C, 32'h0, "R9 full clear");
    expect_at(K_IRQ, 5'h00, 32'h0, "R10 irq cleared");

    // R5 style a: line0 rise, line1 fall, line2 both, line3 reserved(5)
    wr(5'h10, 32'hFF000B1A);
    expect_at(K_RD, 5'h10, 32'h00000B1A, "R5 style a read");
    set_pin(16'h000F);
    idle(3);
    expect_at(K_RD, 5'h0C, 32'h00000005, "R7 rise and both set, R8 reserved quiet");
    idle(3);
    expect_at(K_RD, 5'h0C, 32'h00000005, "R7 edge held");
    wr(5'h0C, 32'h000F);
    idle(3);
    expect_at(K_RD, 5'h0C, 32'h0, "R7 no re-set while high");
    set_pin(16'h0000);
    idle(3);
    expect_at(K_RD, 5'h0C, 32'h00000006, "R7 fall and both set");
    wr(5'h0C, 32'h000F);
    expect_at(K_RD, 5'h0C, 32'h0, "R9 clear edges");

    // R9 event and clear in the same cycle on line2 (either edge)
    set_pin(16'h0004);
    idle(3);
    expect_at(K_RD, 5'h0C, 32'h00000004, "R7 line2 rise");
    @(posedge clk); #2 pin = 16'h0000;
    @(posedge clk);
    @(posedge clk); #2;
    en = 1'b1; we = 1'b1; addr = 5'h0C; wdata = 32'h4;
    @(posedge clk); #2;
    en = 1'b0; we = 1'b0;
    expect_at(K_RD, 5'h0C, 32'h00000004, "R9 event wins over clear");
    wr(5'h0C, 32'h4);
    expect_at(K_RD, 5'h0C, 32'h0, "R9 clear without event");

    // R5 style b: line 8 low-level, R6
    wr(5'h10, 32'h0);
    wr(5'h14, 32'h00000001);
    expect_at(K_RD, 5'h14, 32'h00000001, "R5 style b read");
    expect_at(K_RD, 5'h0C, 32'h00000100, "R6 line8 low level");
    expect_at(K_IRQ, 5'h00, 32'h00000100, "R10 irq line8");
    wr(5'h14, 32'h0);
    wr(5'h0C, 32'hFFFF);
    expect_at(K_RD, 5'h0C, 32'h0, "R6 clear after level gone");

    // R11 holes
    wr(5'h18, 32'hFFFFFFFF);
    wr(5'h1C, 32'hFFFFFFFF);
    expect_at(K_RD, 5'h18, 32'h0, "R11 0x18 reads 0");
    expect_at(K_RD, 5'h1C, 32'h0, "R11 0x1C reads 0");
    expect_at(K_RD, 5'h00, 32'h0000ABCD, "R11 dout untouched");
    expect_at(K_RD, 5'h04, 32'h000000FF, "R11 dir untouched");
    expect_at(K_RD, 5'h10, 32'h0, "R11 style untouched");

    idle(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule